// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

This block is a first-in first-out store for 36-bit words whose writer and reader run on unrelated clocks. Words enter on the write clock while `wr_en` is high and leave on the read clock. Each side computes its own flags from its own pointer and a synchronized copy of the other side's pointer. The pointers carry one wrap bit and cross between the domains as gray code.

The handshake style is picked while master reset is held. In standard mode a word is fetched into the output register by `rd_en`, and the two main flags mean "full" and "empty". In fall-through mode the oldest word shows up on `rdata` without any request, and the two main flags mean "room to write" and "word valid". Three level flags compare the fill level against two offsets and against half the capacity. A partial reset empties the store and keeps the mode. A retransmit request rewinds only the read side.

Top module: `xclk_fifo`

## Requirements
- R1: While `mrst_n` is low and both clocks run, the block zeroes both pointers and `rdata`, and samples `fwft_sel` as the mode (0 = standard, 1 = fall-through). The mode does not change again until the next master reset.
- R2: A low pulse on `prst_n` zeroes both pointers and `rdata` and keeps the current mode, even if `fwft_sel` has changed since master reset.
- R3: In standard mode `full_ir` is 1 exactly when all DEPTH locations hold words, and `empty_or` is 1 when no word is readable. An `rd_en` sampled high while `empty_or` is 0 loads the oldest word into `rdata` at that read-clock edge, so words come out in write order.
- R4: In fall-through mode `empty_or` = 1 means `rdata` holds a valid word, and that word appears without `rd_en`. An `rd_en` sampled while it is valid consumes the word. `full_ir` = 1 means there is room to write. The capacity is DEPTH plus the word held in the output register.
- R5: A write attempted while the store is full is dropped, and the words already stored are not disturbed.
- R6: In standard mode an `rd_en` while `empty_or` is 1 leaves `rdata` and the read pointer unchanged.
- R7: `retx` sampled high on a read-clock edge sets the read pointer to location 0 and leaves the write pointer alone. For the next read cycle the output reports "no word": `empty_or` = 1 in standard mode and 0 in fall-through mode. Reads then restart from the first word written. Rereading from the first word is only well defined when no more than DEPTH words have been written since the last reset.
- R8: `not_afull` is 1 while the free location count (DEPTH minus the stored count, judged in the write domain) is greater than `af_ofs`, and 0 otherwise.
- R9: `not_aempty` is 1 while the stored word count judged in the read domain is at least `ae_ofs`, and 0 otherwise. In fall-through mode the word in the output register is not counted.
- R10: `half_full` is 1 while the stored count judged in the write domain exceeds DEPTH/2.
- R11: In fall-through mode a valid word on `rdata` stays unchanged and valid until it is consumed or a reset or retransmit occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mrst_n | input | 1 | Master reset, active low; clocks must run while it is held |
| prst_n | input | 1 | Partial reset, active low, keeps the mode |
| fwft_sel | input | 1 | Mode select sampled during master reset (1 = fall-through) |
| af_ofs | input | AW+1 | Free-location threshold for `not_afull` |
| ae_ofs | input | AW+1 | Stored-word threshold for `not_aempty` |
| wclk | input | 1 | Write clock |
| wr_en | input | 1 | Write request |
| wdata | input | DW | Write data |
| full_ir | output | 1 | Full (standard) or room-to-write (fall-through) |
| not_afull | output | 1 | High while free locations exceed `af_ofs` |
| half_full | output | 1 | High while more than DEPTH/2 words are stored |
| rclk | input | 1 | Read clock |
| rd_en | input | 1 | Read request |
| retx | input | 1 | Retransmit: rewind the read pointer to location 0 |
| rdata | output | DW | Output register |
| empty_or | output | 1 | Empty (standard) or word-valid (fall-through) |
| not_aempty | output | 1 | High while stored words are at least `ae_ofs` |

## Verification
The bench fills the store one word at a time and then drains it, checking each level flag at every step against a count kept in the bench. A threshold comparison that is off by one flips its flag at the wrong step. It writes past full in both modes. A design that failed to drop that write would return an extra word or lose the oldest one. It issues retransmits after partial draining. A design that rewound the wrong pointer, or did not hide the output for a cycle, would return the wrong first word or show the wrong flag polarity. It changes `fwft_sel` before a partial reset. A design that re-sampled the mode there would report standard-mode flags. Long random runs in each mode, on clocks of different periods, catch ordering and synchronizer errors.

// File: rtl/xclk_fifo.sv
`timescale 1ns/1ps
module xclk_fifo #(
  parameter int DW = 36,
  parameter int AW = 4
) (
  input  logic          mrst_n,
  input  logic          prst_n,
  input  logic          fwft_sel,
  input  logic [AW:0]   af_ofs,
  input  logic [AW:0]   ae_ofs,
  input  logic          wclk,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic          full_ir,
  output logic          not_afull,
  output logic          half_full,
  input  logic          rclk,
  input  logic          rd_en,
  input  logic          retx,
  output logic [DW-1:0] rdata,
  output logic          empty_or,
  output logic          not_aempty
);
  localparam int DEPTH = 1 << AW;
  localparam int PW    = AW + 1;

  function automatic logic [AW:0] b2g(input logic [AW:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [AW:0] g2b(input logic [AW:0] g);
    logic [AW:0] b;
    b[AW] = g[AW];
    for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic rst_n;
  assign rst_n = mrst_n & prst_n;

  logic [DW-1:0] mem [DEPTH];

  // mode registers, one per domain, loaded only under master reset
  logic fwft_w, fwft_r;
  always_ff @(posedge wclk) if (!mrst_n) fwft_w <= fwft_sel;
  always_ff @(posedge rclk) if (!mrst_n) fwft_r <= fwft_sel;

  // write domain
  logic [AW:0] wbin, wgray, rq1, rq2, rbin_w, wcnt;
  logic [AW:0] rgray;
  logic        full, wr_fire;

  assign rbin_w  = g2b(rq2);
  assign wcnt    = wbin - rbin_w;
  assign full    = wcnt[AW];
  assign wr_fire = wr_en & ~full;

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
      rq1   <= '0;
      rq2   <= '0;
    end else begin
      rq1 <= rgray;
      rq2 <= rq1;
      if (wr_fire) begin
        wbin  <= wbin + 1'b1;
        wgray <= b2g(wbin + 1'b1);
      end
    end
  end

  always_ff @(posedge wclk) if (wr_fire) mem[wbin[AW-1:0]] <= wdata;

  assign full_ir   = fwft_w ? ~full : full;
  assign not_afull = (PW'(DEPTH) - wcnt) > af_ofs;
  assign half_full = wcnt > PW'(DEPTH / 2);

  // read domain
  logic [AW:0] rbin, wq1, wq2, wbin_r, rcnt;
  logic        mem_empty, ovalid, rt_q, std_fire, fw_load, pop;

  assign wbin_r    = g2b(wq2);
  assign rcnt      = wbin_r - rbin;
  assign mem_empty = (rcnt == '0);
  assign std_fire  = ~fwft_r & rd_en & ~mem_empty & ~rt_q & ~retx;
  assign fw_load   = fwft_r & ~retx & ~mem_empty & (~ovalid | rd_en);
  assign pop       = std_fire | fw_load;

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rbin   <= '0;
      rgray  <= '0;
      wq1    <= '0;
      wq2    <= '0;
      rdata  <= '0;
      ovalid <= 1'b0;
      rt_q   <= 1'b0;
    end else begin
      wq1  <= wgray;
      wq2  <= wq1;
      rt_q <= retx;
      if (retx) begin
        rbin   <= '0;
        rgray  <= '0;
        ovalid <= 1'b0;
      end else begin
        if (pop) begin
          rbin  <= rbin + 1'b1;
          rgray <= b2g(rbin + 1'b1);
          rdata <= mem[rbin[AW-1:0]];
        end
        if (fw_load)              ovalid <= 1'b1;
        else if (fwft_r && rd_en) ovalid <= 1'b0;
      end
    end
  end

  assign empty_or   = fwft_r ? ovalid : (mem_empty | rt_q);
  assign not_aempty = rcnt >= ae_ofs;
endmodule

// File: rtl/xclk_fifo_chk.sv
`timescale 1ns/1ps
module xclk_fifo_chk #(
  parameter int DW = 36,
  parameter int AW = 4
) (
  input logic          wclk,
  input logic          rclk,
  input logic          rst_n,
  input logic          mrst_n,
  input logic          fwft_r,
  input logic          full,
  input logic          wr_en,
  input logic [AW:0]   wbin,
  input logic          rd_en,
  input logic          retx,
  input logic [AW:0]   rbin,
  input logic          empty_or,
  input logic [DW-1:0] rdata
);
  a_r5_no_overflow: assert property (@(posedge wclk) disable iff (!rst_n)
    (full && wr_en) |=> $stable(wbin));

  a_r6_no_underflow: assert property (@(posedge rclk) disable iff (!rst_n)
    (!fwft_r && empty_or && rd_en && !retx) |=> ($stable(rdata) && $stable(rbin)));

  a_r7_rewind: assert property (@(posedge rclk) disable iff (!rst_n)
    retx |=> (rbin == '0));

  a_r7_hide_output: assert property (@(posedge rclk) disable iff (!rst_n)
    retx |=> (fwft_r ? !empty_or : empty_or));

  a_r11_hold_valid: assert property (@(posedge rclk) disable iff (!rst_n)
    (fwft_r && empty_or && !rd_en && !retx) |=> (empty_or && $stable(rdata)));

  a_r1_mode_kept: assert property (@(posedge rclk) disable iff (!mrst_n)
    $stable(fwft_r));
endmodule

bind xclk_fifo xclk_fifo_chk #(.DW(DW), .AW(AW)) u_chk (
  .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .mrst_n(mrst_n),
  .fwft_r(fwft_r), .full(full), .wr_en(wr_en), .wbin(wbin),
  .rd_en(rd_en), .retx(retx), .rbin(rbin), .empty_or(empty_or),
  .rdata(rdata)
);

// File: tb/tb_xclk_fifo.sv
`timescale 1ns/1ps
module tb_xclk_fifo;
  localparam int DW = 36;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic mrst_n = 0, prst_n = 1, fwft_sel = 0;
  logic [AW:0] af_ofs = 5'd3, ae_ofs = 5'd4;
  logic wclk = 0, rclk = 0;
  logic wr_en = 0, rd_en = 0, retx = 0;
  logic [DW-1:0] wdata = '0;
  logic full_ir, not_afull, half_full, empty_or, not_aempty;
  logic [DW-1:0] rdata;

  int nchk = 0, nfail = 0;
  bit cur_mode = 0;
  logic [DW-1:0] q[$];

  xclk_fifo #(.DW(DW), .AW(AW)) dut (.*);

  always #5 wclk = ~wclk;
  always #6.5 rclk = ~rclk;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] rnd36();
    logic [63:0] t;
    t = {$urandom(), $urandom()};
    return t[DW-1:0];
  endfunction

  function automatic bit can_write();
    return cur_mode ? full_ir : !full_ir;
  endfunction

  task automatic settle();
    repeat (8) @(negedge rclk);
  endtask

  task automatic mreset(bit mode);
    wr_en = 0; rd_en = 0; retx = 0;
    @(negedge wclk);
    mrst_n = 0; fwft_sel = mode; cur_mode = mode;
    #60;
    @(negedge wclk) mrst_n = 1;
    q.delete();
    settle();
  endtask

  task automatic preset();
    @(negedge wclk) prst_n = 0;
    #30;
    @(negedge wclk) prst_n = 1;
    q.delete();
    settle();
  endtask

  task automatic push_word(logic [DW-1:0] d);
    @(negedge wclk);
    while (!can_write()) @(negedge wclk);
    wr_en = 1; wdata = d; q.push_back(d);
    @(negedge wclk) wr_en = 0;
  endtask

  task automatic force_write(logic [DW-1:0] d);
    @(negedge wclk) wr_en = 1; wdata = d;
    @(negedge wclk) wr_en = 0;
  endtask

  task automatic std_read(output logic [DW-1:0] v);
    @(negedge rclk) rd_en = 1;
    @(negedge rclk) rd_en = 0;
    v = rdata;
  endtask

  task automatic fwft_take(string req);
    @(negedge rclk);
    while (!empty_or) @(negedge rclk);
    chk(req, rdata, q.pop_front());
    rd_en = 1;
    @(negedge rclk) rd_en = 0;
  endtask

  task automatic rnd_writer(int n);
    int sent = 0;
    while (sent < n) begin
      @(negedge wclk);
      if (can_write() && ($urandom % 3 != 0)) begin
        wr_en = 1; wdata = rnd36(); q.push_back(wdata); sent++;
      end else wr_en = 0;
    end
    @(negedge wclk) wr_en = 0;
  endtask

  task automatic rnd_reader_std(int n);
    int got = 0;
    bit pend = 0;
    logic [DW-1:0] exp = '0;
    while (got < n) begin
      @(negedge rclk);
      rd_en = 0;
      if (pend) begin chk("R3 order", rdata, exp); pend = 0; got++; end
      if (got < n && !empty_or && q.size() > 0 && ($urandom % 2 == 1)) begin
        rd_en = 1; exp = q.pop_front(); pend = 1;
      end
    end
    rd_en = 0;
  endtask

  task automatic rnd_reader_fwft(int n);
    int got = 0;
    while (got < n) begin
      @(negedge rclk);
      rd_en = 0;
      if (empty_or && q.size() > 0) begin
        chk("R4 order", rdata, q[0]);
        if ($urandom % 2 == 1) begin rd_en = 1; void'(q.pop_front()); got++; end
      end
    end
    @(negedge rclk) rd_en = 0;
  endtask

  initial begin
    #1ms;
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic [DW-1:0] v, w0;
    void'($urandom(32'd7151));

    // reset state, standard mode
    mreset(0);
    chk("R1 rdata cleared", rdata, 0);
    chk("R3 empty at reset", empty_or, 1);
    chk("R3 not full at reset", full_ir, 0);
    chk("R10 half at reset", half_full, 0);
    chk("R8 afull at reset", not_afull, 1);
    chk("R9 aempty at reset", not_aempty, 0);

    std_read(v);
    chk("R6 read on empty rdata", v, 0);
    chk("R6 still empty", empty_or, 1);

    // fill sweep with level flags
    for (int i = 1; i <= DEPTH; i++) begin
      push_word(rnd36());
      settle();
      chk("R10 half_full", half_full, i > DEPTH/2);
      chk("R8 not_afull", not_afull, (DEPTH - i) > 3);
      chk("R9 not_aempty", not_aempty, i >= 4);
      chk("R3 full flag", full_ir, i == DEPTH);
      chk("R3 empty flag", empty_or, 0);
    end
    force_write(36'hBAD_BAD_BAD);
    settle();
    chk("R5 still full", full_ir, 1);
    for (int i = DEPTH; i >= 1; i--) begin
      std_read(v);
      chk("R3 drain order", v, q.pop_front());
      settle();
      chk("R9 not_aempty drain", not_aempty, (i - 1) >= 4);
      chk("R10 half drain", half_full, (i - 1) > DEPTH/2);
    end
    chk("R5 extra word dropped", empty_or, 1);

    // retransmit, standard
    mreset(0);
    for (int i = 0; i < 5; i++) push_word(rnd36());
    settle();
    w0 = q[0];
    std_read(v); chk("R3 first", v, w0);
    std_read(v); chk("R3 second", v, q[1]);
    @(negedge rclk) retx = 1;
    @(negedge rclk) retx = 0;
    chk("R7 empty after retx", empty_or, 1);
    settle();
    chk("R7 data back", empty_or, 0);
    chk("R7 count restored", not_aempty, 1);
    for (int i = 0; i < 5; i++) begin
      std_read(v); chk("R7 reread", v, q.pop_front());
    end
    settle();
    chk("R7 empty after reread", empty_or, 1);

    // random, standard
    mreset(0);
    fork
      rnd_writer(300);
      rnd_reader_std(300);
    join

    // fall-through mode
    mreset(1);
    chk("R1 rdata cleared fwft", rdata, 0);
    chk("R4 no valid at reset", empty_or, 0);
    chk("R4 room at reset", full_ir, 1);
    push_word(36'h123456789);
    settle();
    chk("R4 fall through valid", empty_or, 1);
    chk("R4 fall through data", rdata, 36'h123456789);
    settle();
    chk("R11 held", rdata, 36'h123456789);
    fwft_take("R4 consume");
    settle();
    chk("R4 gone after consume", empty_or, 0);

    for (int i = 0; i < DEPTH + 1; i++) push_word(rnd36());
    settle();
    chk("R4 no room", full_ir, 0);
    force_write(36'hDEAD_0000_1);
    settle();
    for (int i = 0; i < DEPTH + 1; i++) fwft_take("R5 fwft drain");
    settle();
    chk("R5 fwft extra dropped", empty_or, 0);

    // retransmit, fall-through
    mreset(1);
    for (int i = 0; i < 4; i++) push_word(rnd36());
    settle();
    w0 = q[0];
    fwft_take("R4 first");
    settle();
    chk("R4 second shown", rdata, q[0]);
    @(negedge rclk) retx = 1;
    @(negedge rclk) retx = 0;
    chk("R7 fwft hidden", empty_or, 0);
    settle();
    chk("R7 fwft valid", empty_or, 1);
    chk("R7 fwft first again", rdata, w0);

    // random, fall-through
    mreset(1);
    fork
      rnd_writer(300);
      rnd_reader_fwft(300);
    join

    // partial reset keeps fall-through mode
    fwft_sel = 0;
    for (int i = 0; i < 3; i++) push_word(rnd36());
    settle();
    preset();
    chk("R2 rdata cleared", rdata, 0);
    chk("R2 fwft flags kept", empty_or, 0);
    chk("R2 fwft room kept", full_ir, 1);
    push_word(36'h0FACE0FAC);
    settle();
    chk("R2 fwft after prst", empty_or, 1);
    chk("R2 data from start", rdata, 36'h0FACE0FAC);

    // partial reset keeps standard mode
    mreset(0);
    fwft_sel = 1;
    push_word(rnd36()); push_word(rnd36());
    settle();
    std_read(v);
    preset();
    chk("R2 std rdata cleared", rdata, 0);
    chk("R2 std empty", empty_or, 1);
    chk("R2 std not full", full_ir, 0);
    std_read(v);
    chk("R6 read ignored after prst", v, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule